// File: doc/BRIEF.md
# Prioritized Interrupt Sequencer

This block works next to an instruction-cycle controller and decides whether, and which, interrupt is taken at each instruction boundary. Rising edges on a vector of request lines are captured into a pending set. When the controller reports that an instruction has finished, the sequencer checks the pending set. If a request is eligible, the sequencer raises a context-save request to the controller, presents the start address of that line's handler, and pushes the line's priority onto an internal stack of active levels. A return strobe from the handler pops the stack, so the level that was interrupted becomes active again.

Two handling modes can be selected at run time. In sequential mode nothing is taken while any service is active, and requests stay pending until the stack is empty. In nested mode a request whose priority is strictly higher than the active level preempts that level. Requests of equal or lower priority wait. A global enable can stop all takes without losing requests. A return issued with no active service has no effect on the stack and sets a sticky error flag.

Top module: `irq_sequencer`

## Requirements
- R1: After reset, save_req, nest_depth, cur_level, handler_addr and ret_err are all 0.
- R2: A request line is latched as pending only on a 0-to-1 transition sampled by the clock. A line that stays high after it has been taken is not taken a second time.
- R3: A take is considered only in a cycle where instr_done=1, glob_en=1, save_req=0 and rti=0. In every other cycle no interrupt is taken.
- R4: When a take happens, the highest-numbered pending line is chosen (line 7 is the highest priority). On the next clock save_req=1, handler_addr=BASE_ADDR+line*16 (0x0400+line*16 by default), nest_depth rises by one and cur_level equals the line. The pending bit of that line is cleared.
- R5: When nest_mode=0, nothing is taken while nest_depth is nonzero. Requests remain pending and are taken after the service returns.
- R6: When nest_mode=1 and a service is active, a pending line numbered strictly higher than cur_level is taken and becomes cur_level.
- R7: When nest_mode=1, pending lines numbered equal to or lower than cur_level wait until the active level is popped.
- R8: When rti=1 and nest_depth is nonzero, the stack pops on the next clock. nest_depth drops by one and cur_level shows the interrupted level, or 0 when the stack becomes empty.
- R9: When rti=1 and nest_depth=0, the stack is unchanged and ret_err becomes 1. ret_err then stays 1 until reset.
- R10: While glob_en=0 no interrupt is taken, but rising requests are still latched and are taken later once glob_en=1.
- R11: save_req stays at 1 until save_ack=1 is seen, and falls on the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | NUM_LINES | Request lines, higher index means higher priority |
| glob_en | input | 1 | Global permission to take interrupts |
| nest_mode | input | 1 | 0 = sequential handling, 1 = priority-nested handling |
| instr_done | input | 1 | Instruction boundary marker from the controller |
| rti | input | 1 | Return-from-interrupt strobe |
| save_ack | input | 1 | Controller has finished saving context |
| save_req | output | 1 | Context-save request, asserted when an interrupt is taken |
| handler_addr | output | ADDR_W | Start address of the handler for the last interrupt taken |
| cur_level | output | LINE_W | Priority level of the active service (0 when idle) |
| nest_depth | output | DEPTH_W | Number of active levels on the stack |
| ret_err | output | 1 | Sticky flag: a return was issued with the stack empty |

## Verification
The bench uses the default parameters: eight request lines, an eight-entry level stack, 16-bit addresses, base 0x0400 and a 16-byte handler slot. With these values every priority relation can be reached with a few lines: preemption by a strictly higher line, waiting by equal and lower lines, and two-level returns. It can also produce an exact expected handler address per line. A behavioural queue model follows the pending set and the level stack on every clock. Directed cases cover the empty-stack return, a return that coincides with an instruction boundary, take blocking by the enable, and a request line held high.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic {
    MODE_SEQ  = 1'b0,
    MODE_NEST = 1'b1
  } handling_mode_e;

  typedef struct packed {
    logic sample_ok;
    logic eligible;
    logic take;
  } take_decision_t;

endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] req_q, req_q_n;
  logic [N-1:0] pend_q, pend_n;
  logic [N-1:0] rise;

  always_comb begin
    rise    = req_i & ~req_q;
    req_q_n = req_i;
    pend_n  = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_q_n;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  logic [N-1:0]  hit_above;
  logic [N-1:0]  sel;

  // A line is selected when it is pending and no higher line is.
  generate
    for (genvar g = 0; g < N; g++) begin : g_sel
      if (g == N - 1) begin : g_top
        assign hit_above[g] = 1'b0;
      end else begin : g_mid
        assign hit_above[g] = |pend_i[N-1:g+1];
      end
      assign sel[g] = pend_i[g] & ~hit_above[g];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) idx_o = IW'(i);
    end
    any_o = |pend_i;
  end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
  parameter int DEPTH = 8,
  parameter int LW    = 3,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [LW-1:0] push_lvl_i,
  output logic [LW-1:0] top_o,
  output logic [DW-1:0] depth_o,
  output logic          empty_o,
  output logic          full_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] depth_q, depth_n;
  logic [LW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] top_ptr;

  always_comb begin
    empty_o = (depth_q == '0);
    full_o  = (depth_q == DW'(DEPTH));
    wr_ptr  = PW'(depth_q);
    top_ptr = PW'(depth_q - DW'(1));
    top_o   = empty_o ? '0 : mem_q[top_ptr];
    depth_n = depth_q;
    if (push_i && !full_o)      depth_n = depth_q + DW'(1);
    else if (pop_i && !empty_o) depth_n = depth_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= '0;
    else        depth_q <= depth_n;
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic wr_en;
      assign wr_en = push_i && !full_o && (wr_ptr == PW'(e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mem_q[e] <= '0;
        else if (wr_en) mem_q[e] <= push_lvl_i;
      end
    end
  endgenerate

  assign depth_o = depth_q;

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int          NUM_LINES   = 8,
  parameter int          STACK_DEPTH = 8,
  parameter int          ADDR_W      = 16,
  parameter int          SLOT_SHIFT  = 4,
  parameter logic [15:0] BASE_ADDR   = 16'h0400,
  parameter int          LINE_W      = $clog2(NUM_LINES),
  parameter int          DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic                 glob_en,
  input  logic                 nest_mode,
  input  logic                 instr_done,
  input  logic                 rti,
  input  logic                 save_ack,
  output logic                 save_req,
  output logic [ADDR_W-1:0]    handler_addr,
  output logic [LINE_W-1:0]    cur_level,
  output logic [DEPTH_W-1:0]   nest_depth,
  output logic                 ret_err
);
  import irq_seq_pkg::*;

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [NUM_LINES-1:0] pend, clr;
  logic                 pick_any;
  logic [LINE_W-1:0]    pick_idx;
  logic [LINE_W-1:0]    top_lvl;
  logic                 stk_empty, stk_full;
  logic                 do_pop;
  handling_mode_e       mode;
  take_decision_t       dec;

  logic                 save_req_q, save_req_n, save_req_en;
  logic [ADDR_W-1:0]    addr_q, addr_n;
  logic                 addr_en;
  logic                 err_q, err_n, err_en;

  irq_pend_latch #(.N(NUM_LINES)) u_pend (
    .clk    (clk),
    .rst_n  (rst_s2),
    .req_i  (irq_req),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_prio_pick #(.N(NUM_LINES), .IW(LINE_W)) u_pick (
    .pend_i (pend),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  irq_level_stack #(.DEPTH(STACK_DEPTH), .LW(LINE_W), .DW(DEPTH_W)) u_stack (
    .clk        (clk),
    .rst_n      (rst_s2),
    .push_i     (dec.take),
    .pop_i      (do_pop),
    .push_lvl_i (pick_idx),
    .top_o      (top_lvl),
    .depth_o    (nest_depth),
    .empty_o    (stk_empty),
    .full_o     (stk_full)
  );

  // Decision at the instruction boundary.
  always_comb begin
    mode          = handling_mode_e'(nest_mode);
    dec.sample_ok = instr_done & glob_en & ~save_req_q & ~rti;
    dec.eligible  = stk_empty |
                    ((mode == MODE_NEST) & (pick_idx > top_lvl) & ~stk_full);
    dec.take      = dec.sample_ok & pick_any & dec.eligible;
    do_pop        = rti & ~stk_empty;
    clr           = '0;
    if (dec.take) clr[pick_idx] = 1'b1;
  end

  // Next-state for the handshake, address and error flag.
  always_comb begin
    save_req_en = dec.take | (save_req_q & save_ack);
    save_req_n  = dec.take;
    addr_en     = dec.take;
    addr_n      = BASE + (ADDR_W'(pick_idx) << SLOT_SHIFT);
    err_en      = rti & stk_empty;
    err_n       = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      save_req_q <= 1'b0;
      addr_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      if (save_req_en) save_req_q <= save_req_n;
      if (addr_en)     addr_q     <= addr_n;
      if (err_en)      err_q      <= err_n;
    end
  end

  assign save_req     = save_req_q;
  assign handler_addr = addr_q;
  assign cur_level    = top_lvl;
  assign ret_err      = err_q;

endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 16,
  parameter int LINE_W    = 3,
  parameter int DEPTH_W   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_req,
  input logic                 glob_en,
  input logic                 nest_mode,
  input logic                 instr_done,
  input logic                 rti,
  input logic                 save_ack,
  input logic                 save_req,
  input logic [ADDR_W-1:0]    handler_addr,
  input logic [LINE_W-1:0]    cur_level,
  input logic [DEPTH_W-1:0]   nest_depth,
  input logic                 ret_err
);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !save_ack) |=> save_req);

  a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && save_ack) |=> !save_req);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |=> ret_err);

  a_r9_empty_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && nest_depth == '0) |=> (ret_err && nest_depth == '0));

  a_r8_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && nest_depth != '0) |=> (nest_depth == $past(nest_depth) - DEPTH_W'(1)));

  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_done || !glob_en || rti || save_req) |=> !$rose(save_req));

  a_r5_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_mode && nest_depth != '0) |=> !$rose(save_req));

  a_r6_preempt_higher: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(save_req) && $past(nest_depth) != '0) |-> (cur_level > $past(cur_level)));

endmodule

bind irq_sequencer irq_sequencer_chk #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W),
  .LINE_W    (LINE_W),
  .DEPTH_W   (DEPTH_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_s2),
  .irq_req      (irq_req),
  .glob_en      (glob_en),
  .nest_mode    (nest_mode),
  .instr_done   (instr_done),
  .rti          (rti),
  .save_ack     (save_ack),
  .save_req     (save_req),
  .handler_addr (handler_addr),
  .cur_level    (cur_level),
  .nest_depth   (nest_depth),
  .ret_err      (ret_err)
);

// File: tb/tb_irq_sequencer.sv
module tb_irq_sequencer;

  localparam int N = 8;
  localparam int SDEPTH = 8;
  localparam int BASE = 'h0400;

  logic        clk;
  logic        rst_n;
  logic [N-1:0] irq_req;
  logic        glob_en, nest_mode, instr_done, rti, save_ack;
  logic        save_req;
  logic [15:0] handler_addr;
  logic [2:0]  cur_level;
  logic [3:0]  nest_depth;
  logic        ret_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  irq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .glob_en(glob_en),
    .nest_mode(nest_mode), .instr_done(instr_done), .rti(rti),
    .save_ack(save_ack), .save_req(save_req), .handler_addr(handler_addr),
    .cur_level(cur_level), .nest_depth(nest_depth), .ret_err(ret_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model.
  int m_stack[$];
  bit m_pend[N];
  bit m_req_q[N];
  bit m_sreq;
  int m_addr;
  bit m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stack.delete();
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_req_q[i] = 0; end
      m_sreq = 0; m_addr = 0; m_err = 0;
    end else begin
      int pick;
      bit take;
      bit new_sreq;
      pick = -1;
      take = 0;
      for (int i = 0; i < N; i++) if (m_pend[i]) pick = i;
      new_sreq = m_sreq;
      if (rti) begin
        if (m_stack.size() == 0) m_err = 1;
        else void'(m_stack.pop_back());
      end else if (instr_done && glob_en && !m_sreq && pick >= 0) begin
        if (m_stack.size() == 0) take = 1;
        else if (nest_mode && pick > m_stack[$] && m_stack.size() < SDEPTH) take = 1;
      end
      if (m_sreq && save_ack) new_sreq = 0;
      if (take) begin
        m_stack.push_back(pick);
        new_sreq = 1;
        m_addr = BASE + pick * 16;
        m_pend[pick] = 0;
      end
      m_sreq = new_sreq;
      for (int i = 0; i < N; i++) begin
        if (irq_req[i] && !m_req_q[i]) m_pend[i] = 1;
        m_req_q[i] = irq_req[i];
      end
    end
  end

  task automatic expect_eq(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      expect_eq("R11 save_req vs model", int'(save_req), int'(m_sreq));
      expect_eq("R4 handler_addr vs model", int'(handler_addr), m_addr);
      expect_eq("R8 nest_depth vs model", int'(nest_depth), m_stack.size());
      expect_eq("R6 cur_level vs model", int'(cur_level),
                (m_stack.size() == 0) ? 0 : m_stack[$]);
      expect_eq("R9 ret_err vs model", int'(ret_err), int'(m_err));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tap(int line);
    irq_req[line] = 1'b1; step(1); irq_req[line] = 1'b0; step(1);
  endtask

  task automatic done_pulse();
    instr_done = 1'b1; step(1); instr_done = 1'b0;
  endtask

  task automatic ret_pulse();
    rti = 1'b1; step(1); rti = 1'b0;
  endtask

  task automatic ack_pulse();
    save_ack = 1'b1; step(1); save_ack = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; glob_en = 1'b1; nest_mode = 1'b0;
    instr_done = 1'b0; rti = 1'b0; save_ack = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    expect_eq("R1 save_req", save_req, 0);
    expect_eq("R1 nest_depth", nest_depth, 0);
    expect_eq("R1 cur_level", cur_level, 0);
    expect_eq("R1 handler_addr", handler_addr, 0);
    expect_eq("R1 ret_err", ret_err, 0);

    // R3: pending line not taken without an instruction boundary
    tap(3); step(3);
    expect_eq("R3 no take without instr_done", save_req, 0);
    done_pulse();
    expect_eq("R4 take line 3 save_req", save_req, 1);
    expect_eq("R4 line 3 address", handler_addr, 'h430);
    expect_eq("R4 cur_level 3", cur_level, 3);
    step(2);
    expect_eq("R11 save_req held", save_req, 1);
    ack_pulse();
    expect_eq("R11 save_req dropped", save_req, 0);

    // R5 sequential mode holds off line 6
    tap(6); done_pulse();
    expect_eq("R5 no preempt in sequential", nest_depth, 1);
    expect_eq("R5 level unchanged", cur_level, 3);
    ret_pulse();
    expect_eq("R8 pop to empty", nest_depth, 0);
    done_pulse();
    expect_eq("R5 held request taken later", cur_level, 6);
    expect_eq("R5 line 6 address", handler_addr, 'h460);
    ack_pulse(); ret_pulse();

    // R6 / R7 nested mode
    nest_mode = 1'b1;
    tap(2); done_pulse(); ack_pulse();
    tap(5); done_pulse();
    expect_eq("R6 preempt depth", nest_depth, 2);
    expect_eq("R6 preempt level", cur_level, 5);
    ack_pulse();
    tap(4); tap(5); done_pulse();
    expect_eq("R7 lower/equal wait depth", nest_depth, 2);
    expect_eq("R7 lower/equal wait save_req", save_req, 0);
    ret_pulse();
    expect_eq("R8 return to level 2", cur_level, 2);
    done_pulse();
    expect_eq("R4 highest pending of 4,5", cur_level, 5);
    ack_pulse(); ret_pulse(); done_pulse();
    expect_eq("R7 line 4 taken after pop", cur_level, 4);
    ack_pulse(); ret_pulse(); ret_pulse();
    expect_eq("R8 fully unwound", nest_depth, 0);
    expect_eq("R9 no error yet", ret_err, 0);

    // R9 return with empty stack
    ret_pulse();
    expect_eq("R9 error set", ret_err, 1);
    expect_eq("R9 depth unchanged", nest_depth, 0);
    step(3);
    expect_eq("R9 error sticky", ret_err, 1);

    // R10 global enable
    glob_en = 1'b0;
    tap(7); done_pulse();
    expect_eq("R10 blocked", save_req, 0);
    glob_en = 1'b1; done_pulse();
    expect_eq("R10 latched while disabled", cur_level, 7);
    expect_eq("R10 line 7 address", handler_addr, 'h470);
    ack_pulse(); ret_pulse();

    // R2 line held high is taken once
    irq_req[1] = 1'b1; step(1);
    done_pulse();
    expect_eq("R2 held line taken", cur_level, 1);
    ack_pulse(); ret_pulse(); done_pulse();
    expect_eq("R2 no retake while held", nest_depth, 0);
    irq_req[1] = 1'b0; step(1);

    // R3 return and boundary in the same cycle
    tap(0);
    rti = 1'b1; instr_done = 1'b1; step(1); rti = 1'b0; instr_done = 1'b0;
    expect_eq("R3 no take with rti", nest_depth, 0);
    done_pulse();
    expect_eq("R3 taken next boundary", handler_addr, 'h400);
    ack_pulse(); ret_pulse();

    // R4 simultaneous pending lines
    glob_en = 1'b0; tap(1); tap(6); glob_en = 1'b1;
    done_pulse();
    expect_eq("R4 picks 6 over 1", cur_level, 6);
    ack_pulse(); ret_pulse(); done_pulse();
    expect_eq("R4 then line 1", cur_level, 1);
    expect_eq("R4 line 1 address", handler_addr, 'h410);
    ack_pulse(); ret_pulse(); step(2);

    finished = 1;
    summary();
    $finish;
  end

endmodule